// File: doc/BRIEF.md
# Single-Channel Block Transfer Engine

This block is one channel of a memory-transfer engine. It moves data, one element per request, between a peripheral data register and a two-port buffer RAM. The RAM sits inside the block. Its second port is left to the host, so the channel never borrows host cycles. A request comes either from one of twenty peripheral request lines, picked by a select field, or from a software force input. The transfer direction, the element size (byte or 16-bit word) and address post-increment are each set by a configuration input.

The channel counts elements against a programmed block length. When a block ends it raises a one-cycle interrupt; if configured to, it raises it at the half-block point instead. Three things happen at block end, each set by its own input: the channel disables itself or stays enabled, the buffer address reloads, and the channel switches between a primary and a secondary buffer start address. An arm pulse enables the channel and loads its start state.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset, `chan_en_o`, `buf_sel_o`, `irq_o` and `per_we_o` are all 0.
- R2: A one-cycle `arm_i` pulse enables the channel and clears the element count and any pending request. It also selects the primary buffer and loads the address from `cfg_start_a_i`. All of these are visible one cycle later.
- R3: A request is `sw_force_i`, or `irq_lines_i[cfg_sel_i]` when `cfg_sel_i` is below 20; a select value of 20 or more picks no line. A request seen while `chan_en_o` is 0 is dropped and moves no data.
- R4: A request is latched on the clock edge where it is seen and is launched on the next edge, provided the channel is idle. Each element takes three cycles from launch to completion. One pending request is kept: a request that arrives while an element is in flight is serviced once that element ends, and requests that arrive before the launch merge into one.
- R5: With `cfg_dir_i`=0 (peripheral to RAM), `per_rdata_i` is sampled at launch and written to the buffer address. In word mode the full 16 bits go to the word at address>>1. In byte mode bits 7:0 go to the byte lane picked by address bit 0 (0 = low lane).
- R6: With `cfg_dir_i`=1 (RAM to peripheral), the element is read from the buffer address and shown on `per_wdata_o`, with `per_we_o` high for one cycle at completion. A byte element is zero-extended and taken from the lane picked by address bit 0.
- R7: With `cfg_postinc_i`=1, the byte address advances by 1 (byte mode) or 2 (word mode) after each element that does not end a block. With `cfg_postinc_i`=0 it stays fixed.
- R8: The block length is `cfg_count_i` elements (0 means 2^CW). With `cfg_half_i`=0, `irq_o` pulses for one cycle when the last element of a block completes.
- R9: With `cfg_half_i`=1 and a length of at least 2, `irq_o` pulses instead when element number length/2 (rounded down, counting from 1) completes.
- R10: With `cfg_oneshot_i`=1, `chan_en_o` falls in the same cycle in which the last element of a block completes.
- R11: With `cfg_oneshot_i`=0, the channel stays enabled at block end, and the address reloads to the start of the active buffer.
- R12: With `cfg_pingpong_i`=1, `buf_sel_o` toggles at each block end (0 = primary at `cfg_start_a_i`, 1 = secondary at `cfg_start_b_i`), and the next block starts at the newly active buffer's address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | Pulse: enable channel and load start state |
| cfg_dir_i | input | 1 | 0 peripheral to RAM, 1 RAM to peripheral |
| cfg_byte_i | input | 1 | 1 byte elements, 0 word elements |
| cfg_postinc_i | input | 1 | Address post-increment enable |
| cfg_oneshot_i | input | 1 | Disable channel after one block |
| cfg_pingpong_i | input | 1 | Alternate between two buffers |
| cfg_half_i | input | 1 | Interrupt at half block instead of block end |
| cfg_sel_i | input | SELW (5) | Request line select |
| cfg_start_a_i | input | AW (8) | Primary buffer byte address |
| cfg_start_b_i | input | AW (8) | Secondary buffer byte address |
| cfg_count_i | input | CW (8) | Block length in elements |
| irq_lines_i | input | NSRC (20) | Peripheral request lines |
| sw_force_i | input | 1 | Software-forced request |
| per_rdata_i | input | 16 | Peripheral register read value |
| per_wdata_o | output | 16 | Data written to the peripheral register |
| per_we_o | output | 1 | Peripheral write strobe |
| irq_o | output | 1 | Block or half-block interrupt pulse |
| chan_en_o | output | 1 | Channel enabled |
| buf_sel_o | output | 1 | Active buffer (0 primary, 1 secondary) |
| host_addr_i | input | AW-1 (7) | Host port word address |
| host_we_i | input | 1 | Host port write enable |
| host_be_i | input | 2 | Host port byte enables |
| host_wdata_i | input | 16 | Host port write data |
| host_rdata_o | output | 16 | Host port read data, one cycle latency |

## Verification
The bench sends back-to-back requests and requests during an element, and a design that drops the latch would move too few elements. The bench also tests an odd start address in byte mode, where choosing the wrong lane returns the neighbouring byte. Blocks are run past their end in continuous and ping-pong modes, where a missed reload or a missed buffer toggle overwrites the wrong words. The half-block option, requests while disabled and an out-of-range select are also covered; a design that gets one of these wrong gives an interrupt in the wrong cycle or moves data when it should not.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MOVE = 2'd1,
    ST_DONE = 2'd2
  } dma_state_e;

  typedef struct packed {
    logic dir;
    logic byte_mode;
    logic postinc;
    logic oneshot;
    logic pingpong;
    logic half_irq;
  } dma_mode_t;

endpackage

// File: rtl/dma_req_latch.sv
module dma_req_latch #(
  parameter int NSRC = 20,
  parameter int SELW = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            en,
  input  logic            launch,
  input  logic [NSRC-1:0] src_i,
  input  logic [SELW-1:0] sel_i,
  input  logic            force_i,
  output logic            pend_o
);

  logic hit;
  logic pend_q;

  // selected line or software force; out-of-range select matches nothing
  always_comb begin
    hit = force_i;
    for (int i = 0; i < NSRC; i++) begin
      if (sel_i == SELW'(i)) hit = hit | src_i[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) pend_q <= 1'b0;
    else            pend_q <= (pend_q & ~launch) | (hit & en);
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int AW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic          byte_mode,
  input  logic          postinc,
  input  logic          pingpong,
  input  logic [AW-1:0] start_a,
  input  logic [AW-1:0] start_b,
  input  logic [CW-1:0] count,
  output logic [AW-1:0] addr_o,
  output logic          last_o,
  output logic          half_o,
  output logic          buf_o
);

  localparam int LW = CW + 1;

  logic [CW-1:0] cnt_q;
  logic [AW-1:0] addr_q;
  logic          buf_q;
  logic [LW-1:0] len, len_m1, half_m1;
  logic [AW-1:0] stride, nxt_start;

  always_comb begin
    len     = (count == '0) ? (LW'(1) << CW) : {1'b0, count};
    len_m1  = len - LW'(1);
    half_m1 = (len >> 1) - LW'(1);
    last_o  = ({1'b0, cnt_q} == len_m1);
    half_o  = (len >= LW'(2)) && ({1'b0, cnt_q} == half_m1);
    stride  = byte_mode ? AW'(1) : AW'(2);
    if (pingpong) nxt_start = buf_q ? start_a : start_b;
    else          nxt_start = buf_q ? start_b : start_a;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      addr_q <= '0;
      buf_q  <= 1'b0;
    end else if (load) begin
      cnt_q  <= '0;
      addr_q <= start_a;
      buf_q  <= 1'b0;
    end else if (step) begin
      if (last_o) begin
        cnt_q  <= '0;
        addr_q <= nxt_start;
        if (pingpong) buf_q <= ~buf_q;
      end else begin
        cnt_q <= cnt_q + CW'(1);
        if (postinc) addr_q <= addr_q + stride;
      end
    end
  end

  assign addr_o = addr_q;
  assign buf_o  = buf_q;

endmodule

// File: rtl/dma_buf_ram.sv
module dma_buf_ram #(
  parameter int IW = 7,
  parameter int NB = 2,
  localparam int DW = 8 * NB,
  localparam int DEPTH = 1 << IW
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [NB-1:0] a_be,
  input  logic [IW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_we,
  input  logic [NB-1:0] b_be,
  input  logic [IW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NB; i++) begin
      if (a_we && a_be[i]) mem[a_addr][8*i +: 8] <= a_wdata[8*i +: 8];
      if (b_we && b_be[i]) mem[b_addr][8*i +: 8] <= b_wdata[8*i +: 8];
    end
    a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
  end

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine #(
  parameter int AW   = 8,
  parameter int CW   = 8,
  parameter int NSRC = 20,
  localparam int SELW = $clog2(NSRC),
  localparam int IW   = AW - 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            arm_i,
  input  logic            cfg_dir_i,
  input  logic            cfg_byte_i,
  input  logic            cfg_postinc_i,
  input  logic            cfg_oneshot_i,
  input  logic            cfg_pingpong_i,
  input  logic            cfg_half_i,
  input  logic [SELW-1:0] cfg_sel_i,
  input  logic [AW-1:0]   cfg_start_a_i,
  input  logic [AW-1:0]   cfg_start_b_i,
  input  logic [CW-1:0]   cfg_count_i,
  input  logic [NSRC-1:0] irq_lines_i,
  input  logic            sw_force_i,
  input  logic [15:0]     per_rdata_i,
  output logic [15:0]     per_wdata_o,
  output logic            per_we_o,
  output logic            irq_o,
  output logic            chan_en_o,
  output logic            buf_sel_o,
  input  logic [IW-1:0]   host_addr_i,
  input  logic            host_we_i,
  input  logic [1:0]      host_be_i,
  input  logic [15:0]     host_wdata_i,
  output logic [15:0]     host_rdata_o
);

  import dma_pkg::*;

  dma_mode_t  mode;
  dma_state_e st_q;
  logic       en_q, irq_q, we_q;
  logic [15:0] data_q, pwd_q;
  logic       pend, launch, step;
  logic [AW-1:0] addr;
  logic       last, half;
  logic       ram_we;
  logic [1:0] ram_be;
  logic [15:0] ram_wdata, ram_rdata;
  logic [7:0] rd_lane;

  assign mode = '{dir: cfg_dir_i, byte_mode: cfg_byte_i, postinc: cfg_postinc_i,
                  oneshot: cfg_oneshot_i, pingpong: cfg_pingpong_i, half_irq: cfg_half_i};

  assign launch = (st_q == ST_IDLE) && en_q && pend;
  assign step   = (st_q == ST_DONE) && !arm_i;

  dma_req_latch #(.NSRC(NSRC), .SELW(SELW)) u_req (
    .clk(clk), .rst(rst), .clr(arm_i), .en(en_q), .launch(launch),
    .src_i(irq_lines_i), .sel_i(cfg_sel_i), .force_i(sw_force_i), .pend_o(pend)
  );

  dma_addr_gen #(.AW(AW), .CW(CW)) u_agen (
    .clk(clk), .rst(rst), .load(arm_i), .step(step),
    .byte_mode(mode.byte_mode), .postinc(mode.postinc), .pingpong(mode.pingpong),
    .start_a(cfg_start_a_i), .start_b(cfg_start_b_i), .count(cfg_count_i),
    .addr_o(addr), .last_o(last), .half_o(half), .buf_o(buf_sel_o)
  );

  // port A: channel side; write in MOVE for peripheral-to-RAM, read otherwise
  always_comb begin
    ram_we    = (st_q == ST_MOVE) && !mode.dir && !arm_i;
    ram_be    = mode.byte_mode ? (addr[0] ? 2'b10 : 2'b01) : 2'b11;
    ram_wdata = mode.byte_mode ? {data_q[7:0], data_q[7:0]} : data_q;
    rd_lane   = addr[0] ? ram_rdata[15:8] : ram_rdata[7:0];
  end

  dma_buf_ram #(.IW(IW), .NB(2)) u_ram (
    .clk(clk),
    .a_we(ram_we), .a_be(ram_be), .a_addr(addr[AW-1:1]),
    .a_wdata(ram_wdata), .a_rdata(ram_rdata),
    .b_we(host_we_i), .b_be(host_be_i), .b_addr(host_addr_i),
    .b_wdata(host_wdata_i), .b_rdata(host_rdata_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      en_q   <= 1'b0;
      irq_q  <= 1'b0;
      we_q   <= 1'b0;
      data_q <= '0;
      pwd_q  <= '0;
    end else begin
      irq_q <= 1'b0;
      we_q  <= 1'b0;
      if (arm_i) begin
        st_q <= ST_IDLE;
        en_q <= 1'b1;
      end else begin
        unique case (st_q)
          ST_IDLE: if (launch) begin
            data_q <= per_rdata_i;
            st_q   <= ST_MOVE;
          end
          ST_MOVE: st_q <= ST_DONE;
          ST_DONE: begin
            st_q  <= ST_IDLE;
            irq_q <= mode.half_irq ? half : last;
            if (mode.dir) begin
              we_q  <= 1'b1;
              pwd_q <= mode.byte_mode ? {8'h00, rd_lane} : ram_rdata;
            end
            if (last && mode.oneshot) en_q <= 1'b0;
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign per_wdata_o = pwd_q;
  assign per_we_o    = we_q;
  assign irq_o       = irq_q;
  assign chan_en_o   = en_q;

endmodule

// File: rtl/dma_chan_checker.sv
module dma_chan_checker (
  input logic clk,
  input logic rst,
  input logic arm_i,
  input logic cfg_dir_i,
  input logic cfg_oneshot_i,
  input logic cfg_pingpong_i,
  input logic cfg_half_i,
  input logic per_we_o,
  input logic irq_o,
  input logic chan_en_o,
  input logic buf_sel_o
);

  // R6: peripheral strobe only in RAM-to-peripheral direction
  p_we_dir_r6: assert property (@(posedge clk) disable iff (rst)
    per_we_o |-> $past(cfg_dir_i));

  // R6: strobe lasts one cycle
  p_we_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    per_we_o |=> !per_we_o);

  // R8: interrupt is a single-cycle pulse
  p_irq_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);

  // R10: end-of-block interrupt in one-shot mode comes with disable
  p_oneshot_off_r10: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !$past(cfg_half_i) && $past(cfg_oneshot_i) && !$past(arm_i)) |-> !chan_en_o);

  // R12: buffer select moves only in ping-pong mode
  p_buf_pp_r12: assert property (@(posedge clk) disable iff (rst)
    (!$stable(buf_sel_o) && !$past(arm_i)) |-> $past(cfg_pingpong_i));

  // R3: a disabled channel produces no activity
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (!chan_en_o && !arm_i) |=> (!per_we_o && !irq_o));

endmodule

bind dma_chan_engine dma_chan_checker u_chk (
  .clk(clk), .rst(rst), .arm_i(arm_i), .cfg_dir_i(cfg_dir_i),
  .cfg_oneshot_i(cfg_oneshot_i), .cfg_pingpong_i(cfg_pingpong_i),
  .cfg_half_i(cfg_half_i), .per_we_o(per_we_o), .irq_o(irq_o),
  .chan_en_o(chan_en_o), .buf_sel_o(buf_sel_o)
);

// File: tb/tb_dma_chan_engine.sv
module tb_dma_chan_engine;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8, CW = 8, NSRC = 20;

  logic clk = 0, rst = 1, arm = 0;
  logic dir = 0, bmode = 0, pinc = 1, oneshot = 0, pp = 0, half = 0;
  logic [4:0] sel = 5;
  logic [7:0] sa = 8'h10, sb = 8'h40, cnt = 8'd4;
  logic [NSRC-1:0] lines = '0;
  logic force_r = 0;
  logic [15:0] prd = 0, pwd, hwd = 0, hrd;
  logic pwe, irq, en, bsel, hwe = 0;
  logic [1:0] hbe = 2'b11;
  logic [6:0] haddr = 0;

  int total = 0, bad = 0, irq_seen = 0, we_seen = 0, cyc = 0;
  bit running = 0, finished = 0;
  logic [15:0] wq [$];

  dma_chan_engine #(.AW(AW), .CW(CW), .NSRC(NSRC)) dut (
    .clk(clk), .rst(rst), .arm_i(arm), .cfg_dir_i(dir), .cfg_byte_i(bmode),
    .cfg_postinc_i(pinc), .cfg_oneshot_i(oneshot), .cfg_pingpong_i(pp),
    .cfg_half_i(half), .cfg_sel_i(sel), .cfg_start_a_i(sa), .cfg_start_b_i(sb),
    .cfg_count_i(cnt), .irq_lines_i(lines), .sw_force_i(force_r),
    .per_rdata_i(prd), .per_wdata_o(pwd), .per_we_o(pwe), .irq_o(irq),
    .chan_en_o(en), .buf_sel_o(bsel), .host_addr_i(haddr), .host_we_i(hwe),
    .host_be_i(hbe), .host_wdata_i(hwd), .host_rdata_o(hrd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference
  logic [7:0] mb [256];
  bit m_en = 0, m_pend = 0, m_buf = 0, m_irq = 0, m_we = 0;
  int m_phase = 0, m_addr = 0, m_cnt = 0;
  logic [15:0] m_data = 0, m_wd = 0, m_rd = 0;

  always @(posedge clk) begin : model
    bit trig, launch, newp, lst, hlf;
    int len, wi, isel;
    if (rst) begin
      m_en = 0; m_pend = 0; m_buf = 0; m_irq = 0; m_we = 0;
      m_phase = 0; m_addr = 0; m_cnt = 0; m_wd = 0;
    end else begin
      isel = int'(sel);
      trig = force_r || (isel < NSRC && lines[isel]);
      launch = (m_phase == 0) && m_pend && m_en;
      m_irq = 0; m_we = 0;
      if (arm) begin
        m_en = 1; m_pend = 0; m_buf = 0; m_cnt = 0; m_addr = int'(sa); m_phase = 0;
      end else begin
        newp = (launch ? 1'b0 : m_pend) | (trig & m_en);
        wi = m_addr / 2;
        case (m_phase)
          0: if (launch) begin m_data = prd; m_phase = 1; end
          1: begin
            if (!dir) begin
              if (bmode) mb[m_addr] = m_data[7:0];
              else begin mb[2*wi] = m_data[7:0]; mb[2*wi+1] = m_data[15:8]; end
            end else begin
              m_rd = bmode ? {8'h00, mb[m_addr]} : {mb[2*wi+1], mb[2*wi]};
            end
            m_phase = 2;
          end
          default: begin
            len = (cnt == 0) ? 256 : int'(cnt);
            lst = (m_cnt == len - 1);
            hlf = (len >= 2) && (m_cnt == len / 2 - 1);
            if (dir) begin m_we = 1; m_wd = m_rd; end
            m_irq = half ? hlf : lst;
            if (lst) begin
              m_cnt = 0;
              if (pp) m_buf = !m_buf;
              m_addr = m_buf ? int'(sb) : int'(sa);
              if (oneshot) m_en = 0;
            end else begin
              m_cnt++;
              if (pinc) m_addr = (m_addr + (bmode ? 1 : 2)) % 256;
            end
            m_phase = 0;
          end
        endcase
        m_pend = newp;
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (running && !rst) begin
      chk(en == m_en, "R10 chan_en", en, m_en);
      chk(bsel == m_buf, "R12 buf_sel", bsel, m_buf);
      chk(irq == m_irq, "R8 irq", irq, m_irq);
      chk(pwe == m_we, "R6 per_we", pwe, m_we);
      if (m_we) chk(pwd == m_wd, "R6 per_wdata", pwd, m_wd);
      if (irq) irq_seen++;
      if (pwe) begin we_seen++; wq.push_back(pwd); end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic host_write(int wi, logic [15:0] d);
    @(negedge clk); haddr = 7'(wi); hwd = d; hwe = 1; hbe = 2'b11;
    mb[2*wi] = d[7:0]; mb[2*wi+1] = d[15:8];
    @(negedge clk); hwe = 0;
  endtask

  task automatic host_check(int wi, logic [15:0] exp, string tag);
    @(negedge clk); haddr = 7'(wi);
    @(negedge clk);
    chk(hrd == exp, tag, hrd, exp);
    chk(hrd == {mb[2*wi+1], mb[2*wi]}, tag, hrd, {mb[2*wi+1], mb[2*wi]});
  endtask

  task automatic do_arm();
    @(negedge clk); arm = 1; @(negedge clk); arm = 0;
  endtask

  task automatic pulse_line(int idx, int n);
    @(negedge clk); lines[idx] = 1; tick(n); lines = '0; tick(5);
  endtask

  task automatic pulse_force();
    @(negedge clk); force_r = 1; @(negedge clk); force_r = 0; tick(5);
  endtask

  initial begin
    int i0, w0;
    for (int i = 0; i < 256; i++) mb[i] = 8'h00;
    tick(3);
    @(negedge clk); rst = 0;
    chk(en == 0 && bsel == 0 && irq == 0 && pwe == 0, "R1 reset outputs",
        {en, bsel, irq, pwe}, 0);
    for (int w = 0; w < 128; w++) host_write(w, 16'hA500 + 16'(w));
    running = 1;

    // disabled channel ignores requests
    pulse_line(5, 1);
    chk(irq_seen == 0 && we_seen == 0, "R3 disabled ignore", irq_seen + we_seen, 0);
    host_check(8, 16'hA508, "R3 disabled ram");

    // continuous word peripheral-to-RAM, 6 elements over a 4 block
    do_arm();
    chk(en == 1 && bsel == 0, "R2 arm", {en, bsel}, 2'b10);
    for (int k = 0; k < 6; k++) begin prd = 16'h1000 + 16'(k); pulse_line(5, 1); end
    chk(irq_seen == 1, "R8 block irq count", irq_seen, 1);
    chk(en == 1, "R11 stays enabled", en, 1);
    host_check(8, 16'h1004, "R11 reload");
    host_check(9, 16'h1005, "R7 word step");
    host_check(10, 16'h1002, "R5 word write");
    host_check(11, 16'h1003, "R5 word write");

    // one-shot byte RAM-to-peripheral from odd address
    host_write(16, 16'h2211); host_write(17, 16'h4433);
    dir = 1; bmode = 1; oneshot = 1; cnt = 3; sa = 8'h21;
    do_arm();
    wq.delete(); i0 = irq_seen;
    for (int k = 0; k < 3; k++) pulse_force();
    chk(wq.size() == 3, "R6 strobe count", wq.size(), 3);
    if (wq.size() == 3) begin
      chk(wq[0] == 16'h0022, "R6 byte lane hi", wq[0], 16'h0022);
      chk(wq[1] == 16'h0033, "R6 byte lane lo", wq[1], 16'h0033);
      chk(wq[2] == 16'h0044, "R7 byte step", wq[2], 16'h0044);
    end
    chk(en == 0, "R10 one-shot off", en, 0);
    chk(irq_seen == i0 + 1, "R8 one-shot irq", irq_seen, i0 + 1);
    w0 = we_seen; pulse_force();
    chk(we_seen == w0, "R10 after disable", we_seen, w0);

    // ping-pong word peripheral-to-RAM
    dir = 0; bmode = 0; oneshot = 0; pp = 1; cnt = 2; sa = 8'h60; sb = 8'h70;
    do_arm();
    for (int k = 0; k < 5; k++) begin
      prd = 16'h3000 + 16'(k); pulse_line(5, 1);
      if (k == 1) chk(bsel == 1, "R12 to secondary", bsel, 1);
      if (k == 3) chk(bsel == 0, "R12 back to primary", bsel, 0);
    end
    host_check(48, 16'h3004, "R12 primary");
    host_check(49, 16'h3001, "R12 primary");
    host_check(56, 16'h3002, "R12 secondary");
    host_check(57, 16'h3003, "R12 secondary");

    // half-block interrupt
    pp = 0; half = 1; cnt = 4; sa = 8'h80;
    do_arm();
    i0 = irq_seen;
    pulse_line(5, 1);
    chk(irq_seen == i0, "R9 no irq at 1", irq_seen, i0);
    pulse_line(5, 1);
    chk(irq_seen == i0 + 1, "R9 irq at 2", irq_seen, i0 + 1);
    pulse_line(5, 1); pulse_line(5, 1);
    chk(irq_seen == i0 + 1, "R9 none at end", irq_seen, i0 + 1);

    // latched requests
    half = 0; cnt = 8; sa = 8'h90; prd = 16'h7777;
    do_arm();
    pulse_line(5, 2);
    tick(4);
    host_check(72, 16'h7777, "R4 first element");
    host_check(73, 16'h7777, "R4 latched element");
    host_check(74, 16'hA54A, "R4 merged no extra");
    sel = 5'd25; prd = 16'h6666;
    @(negedge clk); lines = '1; @(negedge clk); lines = '0; tick(6);
    host_check(74, 16'hA54A, "R3 select out of range");
    sel = 5'd5;

    // fixed address RAM-to-peripheral word
    dir = 1; pinc = 0; cnt = 3; sa = 8'h20;
    do_arm();
    wq.delete();
    for (int k = 0; k < 3; k++) pulse_force();
    chk(wq.size() == 3, "R7 fixed count", wq.size(), 3);
    foreach (wq[j]) chk(wq[j] == 16'h2211, "R7 fixed address", wq[j], 16'h2211);

    tick(3);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule